// File: doc/BRIEF.md
# Queue-Fed Move and Routing Unit

This block is the data-routing unit of a processor whose functional units talk through small operand queues rather than a shared register file. Three data queues feed it (operand A, operand B and a return-address queue) and a fourth queue carries one-bit conditions. A decoded move instruction arrives on its own handshake with a 2-bit operation code, a primary destination tag and a secondary destination tag. The unit waits until every operand that the operation needs is at the head of its queue, takes all of them in the same cycle, and then sends one or two tagged tokens to the routing network through a single valid/ready output.

Four operations exist: a condition-driven choice between A and B, forwarding of a return address, an ordered pair (A then B to one destination), and a copy of A to two destinations. Only one instruction is in the unit at a time, so tokens from different instructions never overtake each other. A stall output rises while the current instruction waits on an empty queue, so a surrounding model can spot a deadlock.

Top module: `move_router`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid and stall are 0, while ins_ready, opa_ready, opb_ready, lnk_ready and cnd_ready are 1.
- R2: Operation code 0 (conditional choice) takes one entry each from the A, B and condition queues and emits a single token tagged ins_dst carrying the A value when the condition bit is 1 and the B value when it is 0; the unselected value is dropped.
- R3: Operation code 1 (return forward) takes one entry from the return-address queue and emits it as a single token tagged ins_dst.
- R4: Operation code 2 (ordered pair) takes one A and one B entry and emits two tokens, both tagged ins_dst, the A value in the first and the B value in the second.
- R5: Operation code 3 (copy) takes one A entry and emits it twice: first tagged ins_dst, then tagged ins_dst2.
- R6: Each input queue holds exactly 2 entries, its ready output is low exactly when it holds 2, and entries leave in arrival order.
- R7: ins_ready is 1 only when no instruction is held; after an instruction handshake it stays 0 until the edge on which the instruction's last token is accepted.
- R8: stall is 1 exactly in the cycles where a held instruction has not yet taken its operands and at least one queue it needs is empty.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_tag keep their values into the next cycle.
- R10: When all needed operands are present, the operands are taken in the cycle after the instruction handshake and the first token is valid in the cycle after that; the second token, if any, is valid in the cycle after the first is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opa_valid | input | 1 | Operand A push valid |
| opa_ready | output | 1 | Operand A queue has room |
| opa_data | input | DW | Operand A value |
| opb_valid | input | 1 | Operand B push valid |
| opb_ready | output | 1 | Operand B queue has room |
| opb_data | input | DW | Operand B value |
| lnk_valid | input | 1 | Return-address push valid |
| lnk_ready | output | 1 | Return-address queue has room |
| lnk_data | input | DW | Return address |
| cnd_valid | input | 1 | Condition push valid |
| cnd_ready | output | 1 | Condition queue has room |
| cnd_bit | input | 1 | Condition value |
| ins_valid | input | 1 | Instruction valid |
| ins_ready | output | 1 | Unit can take an instruction |
| ins_op | input | 2 | Operation code (0 choice, 1 return forward, 2 ordered pair, 3 copy) |
| ins_dst | input | 3 | Primary destination tag |
| ins_dst2 | input | 3 | Secondary destination tag (copy only) |
| out_valid | output | 1 | Output token valid |
| out_ready | input | 1 | Routing network accepts the token |
| out_data | output | DW | Output token value |
| out_tag | output | 3 | Output token destination tag |
| stall | output | 1 | Held instruction is waiting on an empty queue |

## Verification
The hardest situation to reach is an instruction sitting in the unit with only part of its operands present while the output is simultaneously back-pressured, since the ready/valid timing of four queues and the output must line up. The bench gates each queue's source and the output ready independently, first in directed runs (an ordered pair whose B source is held off, a copy whose second token is refused for several cycles, a queue filled with no instruction to drain it) and then in a long run where all gates toggle pseudo-randomly per cycle while a behavioural queue model predicts every port on every clock.

// File: rtl/mvr_pkg.sv
package mvr_pkg;

    localparam int TAG_W = 3;

    typedef enum logic [1:0] {
        OP_CSEL = 2'd0,
        OP_LINK = 2'd1,
        OP_SEQ  = 2'd2,
        OP_DUP  = 2'd3
    } mv_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_EMIT1  = 2'd2,
        ST_EMIT2  = 2'd3
    } mv_state_e;

    typedef struct packed {
        mv_op_e             op;
        logic [TAG_W-1:0]   dst;
        logic [TAG_W-1:0]   dst2;
    } mv_instr_t;

    function automatic logic uses_a(mv_op_e op);
        return op != OP_LINK;
    endfunction

    function automatic logic uses_b(mv_op_e op);
        return (op == OP_CSEL) || (op == OP_SEQ);
    endfunction

    function automatic logic uses_l(mv_op_e op);
        return op == OP_LINK;
    endfunction

    function automatic logic uses_c(mv_op_e op);
        return op == OP_CSEL;
    endfunction

    function automatic logic emits_two(mv_op_e op);
        return (op == OP_SEQ) || (op == OP_DUP);
    endfunction

endpackage

// File: rtl/mvr_fifo.sv
module mvr_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push, take;

    assign in_ready   = count != CW'(DEPTH);
    assign head_valid = count != '0;
    assign head_data  = mem[rd_ptr];
    assign push       = in_valid && in_ready;
    assign take       = pop && head_valid;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= in_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (take) rd_ptr <= bump(rd_ptr);
            case ({push, take})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mvr_seq.sv
module mvr_seq
    import mvr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  mv_instr_t        ins,
    input  logic             a_hv,
    input  logic [DW-1:0]    a_hd,
    input  logic             b_hv,
    input  logic [DW-1:0]    b_hd,
    input  logic             l_hv,
    input  logic [DW-1:0]    l_hd,
    input  logic             c_hv,
    input  logic             c_hd,
    output logic             pop_a,
    output logic             pop_b,
    output logic             pop_l,
    output logic             pop_c,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DW-1:0]    out_data,
    output logic [TAG_W-1:0] out_tag,
    output logic             stall
);
    mv_state_e        state;
    mv_instr_t        cur;
    logic [DW-1:0]    tok1_d, tok2_d;
    logic [TAG_W-1:0] tok2_t;
    logic             have, go;
    logic [DW-1:0]    first_d, second_d;

    // all needed heads present at once; operands are taken together
    assign have = (!uses_a(cur.op) || a_hv) && (!uses_b(cur.op) || b_hv)
               && (!uses_l(cur.op) || l_hv) && (!uses_c(cur.op) || c_hv);
    assign go   = (state == ST_GATHER) && have;

    assign pop_a = go && uses_a(cur.op);
    assign pop_b = go && uses_b(cur.op);
    assign pop_l = go && uses_l(cur.op);
    assign pop_c = go && uses_c(cur.op);

    always_comb begin
        case (cur.op)
            OP_CSEL: first_d = c_hd ? a_hd : b_hd;
            OP_LINK: first_d = l_hd;
            default: first_d = a_hd;
        endcase
        second_d = (cur.op == OP_SEQ) ? b_hd : a_hd;
    end

    assign ins_ready = state == ST_IDLE;
    assign stall     = (state == ST_GATHER) && !have;
    assign out_valid = (state == ST_EMIT1) || (state == ST_EMIT2);
    assign out_data  = (state == ST_EMIT2) ? tok2_d : tok1_d;
    assign out_tag   = (state == ST_EMIT2) ? tok2_t : cur.dst;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur    <= '0;
            tok1_d <= '0;
            tok2_d <= '0;
            tok2_t <= '0;
        end else begin
            case (state)
                ST_IDLE: if (ins_valid) begin
                    cur   <= ins;
                    state <= ST_GATHER;
                end
                ST_GATHER: if (have) begin
                    tok1_d <= first_d;
                    tok2_d <= second_d;
                    tok2_t <= (cur.op == OP_DUP) ? cur.dst2 : cur.dst;
                    state  <= ST_EMIT1;
                end
                ST_EMIT1: if (out_ready)
                    state <= emits_two(cur.op) ? ST_EMIT2 : ST_IDLE;
                default: if (out_ready)
                    state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/move_router.sv
module move_router
    import mvr_pkg::*;
#(
    parameter int DW     = 16,
    parameter int QDEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             opa_valid,
    output logic             opa_ready,
    input  logic [DW-1:0]    opa_data,
    input  logic             opb_valid,
    output logic             opb_ready,
    input  logic [DW-1:0]    opb_data,
    input  logic             lnk_valid,
    output logic             lnk_ready,
    input  logic [DW-1:0]    lnk_data,
    input  logic             cnd_valid,
    output logic             cnd_ready,
    input  logic             cnd_bit,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  logic [1:0]       ins_op,
    input  logic [TAG_W-1:0] ins_dst,
    input  logic [TAG_W-1:0] ins_dst2,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DW-1:0]    out_data,
    output logic [TAG_W-1:0] out_tag,
    output logic             stall
);
    localparam int NDQ = 3;   // A, B, return-address queues

    logic          q_vin  [NDQ];
    logic          q_rdy  [NDQ];
    logic [DW-1:0] q_din  [NDQ];
    logic          q_pop  [NDQ];
    logic          q_hv   [NDQ];
    logic [DW-1:0] q_hd   [NDQ];
    logic          c_pop, c_hv;
    logic          c_hd;
    mv_instr_t     ins;

    assign q_vin[0] = opa_valid;
    assign q_vin[1] = opb_valid;
    assign q_vin[2] = lnk_valid;
    assign q_din[0] = opa_data;
    assign q_din[1] = opb_data;
    assign q_din[2] = lnk_data;
    assign opa_ready = q_rdy[0];
    assign opb_ready = q_rdy[1];
    assign lnk_ready = q_rdy[2];

    generate
        for (genvar i = 0; i < NDQ; i++) begin : g_dq
            mvr_fifo #(.W(DW), .DEPTH(QDEPTH)) u_q (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (q_vin[i]),
                .in_ready  (q_rdy[i]),
                .in_data   (q_din[i]),
                .pop       (q_pop[i]),
                .head_valid(q_hv[i]),
                .head_data (q_hd[i])
            );
        end
    endgenerate

    mvr_fifo #(.W(1), .DEPTH(QDEPTH)) u_cq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (cnd_valid),
        .in_ready  (cnd_ready),
        .in_data   (cnd_bit),
        .pop       (c_pop),
        .head_valid(c_hv),
        .head_data (c_hd)
    );

    assign ins = '{op: mv_op_e'(ins_op), dst: ins_dst, dst2: ins_dst2};

    mvr_seq #(.DW(DW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ins_valid(ins_valid),
        .ins_ready(ins_ready),
        .ins      (ins),
        .a_hv     (q_hv[0]),
        .a_hd     (q_hd[0]),
        .b_hv     (q_hv[1]),
        .b_hd     (q_hd[1]),
        .l_hv     (q_hv[2]),
        .l_hd     (q_hd[2]),
        .c_hv     (c_hv),
        .c_hd     (c_hd),
        .pop_a    (q_pop[0]),
        .pop_b    (q_pop[1]),
        .pop_l    (q_pop[2]),
        .pop_c    (c_pop),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_data),
        .out_tag  (out_tag),
        .stall    (stall)
    );
endmodule

// File: rtl/mvr_chk.sv
module mvr_chk #(
    parameter int DW = 16,
    parameter int TW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          ins_valid,
    input logic          ins_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic [TW-1:0] out_tag,
    input logic          stall,
    input logic          pop_a,
    input logic          pop_b,
    input logic          pop_c,
    input logic          a_hv,
    input logic          b_hv,
    input logic          c_hv
);
    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_ready) |=> !ins_ready);

    // R7
    no_issue_while_emitting_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !ins_ready);

    // R9
    hold_token_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!out_valid && !ins_ready));

    // R6
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_a |-> a_hv) and (pop_b |-> b_hv) and (pop_c |-> c_hv));

    // R2
    cond_with_pair_chk: assert property (@(posedge clk) disable iff (rst)
        pop_c |-> (pop_a && pop_b));

    // R10
    token_follows_take_chk: assert property (@(posedge clk) disable iff (rst)
        pop_a |=> out_valid);
endmodule

bind move_router mvr_chk #(.DW(DW), .TW(mvr_pkg::TAG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ins_valid(ins_valid),
    .ins_ready(ins_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_tag  (out_tag),
    .stall    (stall),
    .pop_a    (q_pop[0]),
    .pop_b    (q_pop[1]),
    .pop_c    (c_pop),
    .a_hv     (q_hv[0]),
    .b_hv     (q_hv[1]),
    .c_hv     (c_hv)
);

// File: tb/move_router_test.sv
module move_router_test;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          opa_valid = 0, opb_valid = 0, lnk_valid = 0, cnd_valid = 0;
    logic [DW-1:0] opa_data = '0, opb_data = '0, lnk_data = '0;
    logic          cnd_bit = 0;
    logic          ins_valid = 0;
    logic [1:0]    ins_op = '0;
    logic [2:0]    ins_dst = '0, ins_dst2 = '0;
    logic          out_ready = 0;
    logic          opa_ready, opb_ready, lnk_ready, cnd_ready, ins_ready;
    logic          out_valid, stall;
    logic [DW-1:0] out_data;
    logic [2:0]    out_tag;

    move_router #(.DW(DW), .QDEPTH(2)) uut (.*);

    // stimulus sources and gates
    int   sa[$], sb[$], sl[$];
    bit   sc[$];
    int   si[$];              // {op,dst,dst2} packed as op*64+dst*8+dst2
    bit   ga = 1, gb = 1, gl = 1, gc = 1, gi = 1;
    int   ordy_mode = 0;      // 0 ready, 1 random, 2 refused
    bit   rnd_gates = 0;

    // behavioural model
    int   qa[$], qb[$], ql[$];
    bit   qc[$];
    int   ph = 0;             // 0 idle, 1 waiting for operands, 2 first token, 3 second token
    int   m_op = 0, m_dst = 0, m_dst2 = 0;
    int   e1d = 0, e1t = 0, e2d = 0, e2t = 0;
    bit   held = 0;
    int   checks = 0, errors = 0, cyc = 0;
    bit   seen_edge = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic bit needs_ok();
        case (m_op)
            0: return qa.size() > 0 && qb.size() > 0 && qc.size() > 0;
            1: return ql.size() > 0;
            2: return qa.size() > 0 && qb.size() > 0;
            default: return qa.size() > 0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        seen_edge = 1;
        if (cyc > 60000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 60000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (rst) begin
            qa.delete(); qb.delete(); ql.delete(); qc.delete();
            ph = 0; held = 0;
            opa_valid <= 0; opb_valid <= 0; lnk_valid <= 0; cnd_valid <= 0;
            ins_valid <= 0; out_ready <= 0;
        end else begin
            bit fa, fb, fl, fc, fi, fo;
            fa = opa_valid && qa.size() < 2;
            fb = opb_valid && qb.size() < 2;
            fl = lnk_valid && ql.size() < 2;
            fc = cnd_valid && qc.size() < 2;
            fi = ins_valid && ph == 0;
            fo = out_ready && (ph == 2 || ph == 3);
            held = (ph == 2 || ph == 3) && !out_ready;
            case (ph)
                0: if (fi) begin
                    m_op = int'(ins_op); m_dst = int'(ins_dst); m_dst2 = int'(ins_dst2);
                    ph = 1;
                end
                1: if (needs_ok()) begin
                    int va, vb;
                    bit vc;
                    va = 0; vb = 0; vc = 0;
                    case (m_op)
                        0: begin va = qa.pop_front(); vb = qb.pop_front(); vc = qc.pop_front();
                                 e1d = vc ? va : vb; end
                        1: e1d = ql.pop_front();
                        2: begin va = qa.pop_front(); vb = qb.pop_front(); e1d = va; e2d = vb; end
                        default: begin va = qa.pop_front(); e1d = va; e2d = va; end
                    endcase
                    e1t = m_dst;
                    e2t = (m_op == 3) ? m_dst2 : m_dst;
                    ph = 2;
                end
                2: if (fo) ph = (m_op >= 2) ? 3 : 0;
                default: if (fo) ph = 0;
            endcase
            if (fa) qa.push_back(int'(opa_data));
            if (fb) qb.push_back(int'(opb_data));
            if (fl) ql.push_back(int'(lnk_data));
            if (fc) qc.push_back(cnd_bit);
            if (fa) void'(sa.pop_front());
            if (fb) void'(sb.pop_front());
            if (fl) void'(sl.pop_front());
            if (fc) void'(sc.pop_front());
            if (fi) void'(si.pop_front());
            if (rnd_gates) begin
                ga = ($urandom % 3) != 0; gb = ($urandom % 3) != 0;
                gl = ($urandom % 3) != 0; gc = ($urandom % 3) != 0;
                gi = ($urandom % 4) != 0;
            end
            opa_valid <= ga && sa.size() > 0;
            opa_data  <= sa.size() > 0 ? DW'(sa[0]) : '0;
            opb_valid <= gb && sb.size() > 0;
            opb_data  <= sb.size() > 0 ? DW'(sb[0]) : '0;
            lnk_valid <= gl && sl.size() > 0;
            lnk_data  <= sl.size() > 0 ? DW'(sl[0]) : '0;
            cnd_valid <= gc && sc.size() > 0;
            cnd_bit   <= sc.size() > 0 ? sc[0] : 1'b0;
            ins_valid <= gi && si.size() > 0;
            ins_op    <= si.size() > 0 ? 2'(si[0] / 64) : '0;
            ins_dst   <= si.size() > 0 ? 3'((si[0] / 8) % 8) : '0;
            ins_dst2  <= si.size() > 0 ? 3'(si[0] % 8) : '0;
            case (ordy_mode)
                0: out_ready <= 1'b1;
                1: out_ready <= ($urandom % 2) != 0;
                default: out_ready <= 1'b0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (seen_edge) begin
            string rq, oq;
            bit ev;
            rq = rst ? "R1" : "";
            ev = (ph == 2 || ph == 3);
            case (m_op)
                0: oq = "R2";
                1: oq = "R3";
                2: oq = "R4";
                default: oq = "R5";
            endcase
            if (held) oq = "R9";
            if (rst) oq = "R1";
            check(out_valid == ev, rst ? "R1" : "R10", "out_valid", int'(out_valid), int'(ev));
            check(ins_ready == (ph == 0), rst ? "R1" : "R7", "ins_ready", int'(ins_ready), int'(ph == 0));
            check(stall == (ph == 1 && !needs_ok()), rst ? "R1" : "R8", "stall",
                  int'(stall), int'(ph == 1 && !needs_ok()));
            check(opa_ready == (qa.size() < 2), rst ? "R1" : "R6", "opa_ready", int'(opa_ready), int'(qa.size() < 2));
            check(opb_ready == (qb.size() < 2), rst ? "R1" : "R6", "opb_ready", int'(opb_ready), int'(qb.size() < 2));
            check(lnk_ready == (ql.size() < 2), rst ? "R1" : "R6", "lnk_ready", int'(lnk_ready), int'(ql.size() < 2));
            check(cnd_ready == (qc.size() < 2), rst ? "R1" : "R6", "cnd_ready", int'(cnd_ready), int'(qc.size() < 2));
            if (ev && out_valid) begin
                int xd, xt;
                xd = (ph == 2) ? e1d : e2d;
                xt = (ph == 2) ? e1t : e2t;
                check(int'(out_data) == xd, oq, "out_data", int'(out_data), xd);
                check(int'(out_tag) == xt, oq, "out_tag", int'(out_tag), xt);
            end
        end
    end

    task automatic put_ins(int op, int dst, int dst2);
        si.push_back(op * 64 + dst * 8 + dst2);
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while ((sa.size() + sb.size() + sl.size() + sc.size() + si.size() != 0 || ph != 0)
                   && guard < 2000);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);

        // R2: choice with condition true then false
        put_ins(0, 5, 0); sa.push_back('h11); sb.push_back('h22); sc.push_back(1);
        put_ins(0, 2, 0); sa.push_back('h33); sb.push_back('h44); sc.push_back(0);
        drain();
        // R3: return-address forward
        put_ins(1, 3, 0); sl.push_back('hABC);
        drain();
        // R4: ordered pair
        put_ins(2, 4, 0); sa.push_back('h101); sb.push_back('h202);
        drain();
        // R5: copy to two destinations
        put_ins(3, 1, 6); sa.push_back('h777);
        drain();
        // R8: instruction waiting on B
        gb = 0;
        put_ins(2, 7, 0); sa.push_back('h5); sb.push_back('h6);
        repeat (6) @(negedge clk);
        gb = 1;
        drain();
        // R9: refused output during a copy
        ordy_mode = 2;
        put_ins(3, 0, 7); sa.push_back('h99);
        repeat (8) @(negedge clk);
        ordy_mode = 0;
        drain();
        // R6: A queue fills with no instruction to drain it
        gi = 0;
        sa.push_back('h1); sa.push_back('h2); sa.push_back('h3);
        repeat (6) @(negedge clk);
        gi = 1;
        put_ins(3, 1, 2); put_ins(3, 3, 4); put_ins(3, 5, 6);
        drain();
        // R7, R10: mixed traffic with random gating and back-pressure
        rnd_gates = 1;
        ordy_mode = 1;
        for (int k = 0; k < 300; k++) begin
            int op;
            op = $urandom % 4;
            put_ins(op, $urandom % 8, $urandom % 8);
            case (op)
                0: begin sa.push_back($urandom % 65536); sb.push_back($urandom % 65536);
                         sc.push_back(1'($urandom % 2)); end
                1: sl.push_back($urandom % 65536);
                2: begin sa.push_back($urandom % 65536); sb.push_back($urandom % 65536); end
                default: sa.push_back($urandom % 65536);
            endcase
        end
        drain();
        rnd_gates = 0;
        ga = 1; gb = 1; gl = 1; gc = 1; gi = 1;
        ordy_mode = 0;
        drain();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule